// File: doc/BRIEF.md
# I2C Command Master

This block is an I2C bus master that a host drives through a small bank of registers. The host picks a pin pair and a bus rate in a select register, then writes one command word. That word holds the 7-bit target address, the direction, a 9-bit byte count, an optional one-byte register index and the cycle kind. The master then drives START, the address byte, any index bytes, the data bytes and the acknowledge slots on open-drain SCL and SDA lines.

Data passes through a single 32-bit data register. Each word holds up to four bytes, with the first byte on the bus in the least significant byte. A hardware-ready status bit tells the host when the next word must be supplied or collected. A transfer command never ends with STOP. It ends in a wait phase that holds SCL low. From there the host either issues another transfer, which gives a repeated START, or issues a stop-cycle command. A target that does not acknowledge sets a sticky error bit. A soft-clear command removes that bit.

Register offsets on `reg_addr`:
- 0: select
- 1: command
- 2: data
- 3: status
- 4: interrupt enable
- 5: 16-bit index

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, status (offset 3) reads 0, both `scl_oe` and `sda_oe` are 0, and `irq` is 0.
- R2: Select register bits 7:0 appear on `pin_sel`, and bits 9:8 are the rate `r`. One SCL period lasts 4·QDIV·2^(3−r) clock cycles.
- R3: Command bits are: [0] go, [1] read, [8:2] address, [17:9] count, [25:18] index byte, [26] index cycle, [27] stop cycle, [31] soft clear. For a write, the host loads data word 0 before the command. The bytes go out least significant byte first, MSB first within each byte. Status bit 0 (hardware-ready) asserts once for each further word, which makes ceil(N/4)−1 handshakes. SDA does not change while SCL is released inside a byte.
- R4: For a read, hardware-ready asserts once per received word, which makes ceil(N/4) handshakes. The bytes are packed least significant byte first, and unused upper bytes of a partial word read 0. The master acknowledges every byte except the last.
- R5: With command bit 26 set, the index byte from bits 25:18 is sent after the address and before the data.
- R6: With bit 31 of the index register (offset 5) set, two index bytes are sent, bits 15:8 first and then bits 7:0. These replace the one-byte index.
- R7: An indexed read sends the address with the write direction, then the index, then a repeated START and the address with the read direction, then the data.
- R8: A transfer command ends in a wait phase: status bit 2 is set and SCL is held low. Only a stop-cycle command (bit 27) issued in the wait phase produces STOP. A stop-cycle command issued while idle has no effect.
- R9: A missing acknowledge on an address, index or write byte does four things: it sets the sticky status bit 1, issues STOP, clears active and releases both lines.
- R10: A command write with bit 31 set returns the controller to idle and clears status bits 0 to 3.
- R11: Status bit 3 (active) is set from command acceptance until a STOP completes. While it is clear, both lines are released.
- R12: `irq` follows only the lowest set bit of the interrupt-enable register: bit 0 hardware-ready, bit 1 wait phase, bit 2 idle.
- R13: A command with count 0 produces only the address and index phases, then the wait phase.
- R14: A host read or write of the data register clears hardware-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| pin_sel | output | 8 | Selected pin pair |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The hardest situations to reach are those where the host handshake and the bus phases interleave. Examples are a word boundary falling mid-transfer, an indexed read that needs a repeated START, and a transfer chained from the wait phase of the previous one. The bench includes a behavioural target on the open-drain lines. It acknowledges its own address, logs every byte it receives and serves a computed byte sequence on reads. Randomly sized reads and writes with random index modes are then issued back to back with no STOP between them, so that every transfer after the first begins with a repeated START. A target address that nobody answers drives the error path.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int QDIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic [7:0]  pin_sel,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  localparam int CW   = $clog2(QDIV * 8) + 1;
  localparam int CNTW = 9;

  typedef enum logic [2:0] {IDLE, START, BYTE, WAITP, STOP} st_t;
  typedef enum logic [2:0] {ADDR, IDXH, IDXL, RADDR, DATA} sp_t;

  st_t st;
  sp_t sp, nsp;
  logic [9:0]      sel_q;
  logic [2:0]      ien_q;
  logic            idx_en;
  logic [15:0]     idx_q;
  logic            c_rd, c_idx;
  logic [6:0]      c_addr;
  logic [7:0]      c_ib, rxsh, txbyte;
  logic [CNTW-1:0] rem;
  logic [1:0]      pos, ph;
  logic [3:0]      bc;
  logic            ackbad, hw_rdy, nak, active, scl_q, sda_q;
  logic [31:0]     dbuf;
  logic [CW-1:0]   cnt, qlen;

  wire in_byte  = (st == BYTE);
  wire in_wait  = (st == WAITP);
  wire busy_t   = (st == START) || in_byte || (st == STOP);
  wire has_idx  = idx_en | c_idx;
  wire rx       = (sp == DATA) && c_rd;
  wire cmd_wr   = reg_wr && (reg_addr == 3'd1);
  wire soft_clr = cmd_wr && reg_wdata[31];
  wire cmd_go   = cmd_wr && reg_wdata[0] && !reg_wdata[31];
  wire data_rd  = reg_rd && (reg_addr == 3'd2);
  wire stall    = in_byte && (sp == DATA) && (pos == 2'd0) && (bc == 4'd0) && (ph == 2'd0) && hw_rdy;

  assign qlen = CW'(QDIV) << (2'd3 - sel_q[9:8]);
  wire tick = busy_t && (cnt == qlen - CW'(1));

  always_comb begin
    case (sp)
      ADDR:    nsp = idx_en ? IDXH : (c_idx ? IDXL : DATA);
      IDXH:    nsp = IDXL;
      IDXL:    nsp = c_rd ? RADDR : DATA;
      default: nsp = DATA;
    endcase
    case (sp)
      ADDR:    txbyte = {c_addr, c_rd & ~has_idx};
      IDXH:    txbyte = idx_q[15:8];
      IDXL:    txbyte = idx_en ? idx_q[7:0] : c_ib;
      RADDR:   txbyte = {c_addr, 1'b1};
      default: txbyte = dbuf[{pos, 3'b000} +: 8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; sp <= ADDR; sel_q <= '0; ien_q <= '0; idx_en <= 1'b0; idx_q <= '0;
      c_rd <= 1'b0; c_idx <= 1'b0; c_addr <= '0; c_ib <= '0; rxsh <= '0; rem <= '0;
      pos <= '0; ph <= '0; bc <= '0; ackbad <= 1'b0; hw_rdy <= 1'b0; nak <= 1'b0;
      active <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0; dbuf <= '0; cnt <= '0;
    end else begin
      cnt <= (tick || !busy_t) ? '0 : cnt + CW'(1);
      if (reg_wr) begin
        case (reg_addr)
          3'd0: sel_q <= reg_wdata[9:0];
          3'd2: begin dbuf <= reg_wdata; hw_rdy <= 1'b0; end
          3'd4: ien_q <= reg_wdata[2:0];
          3'd5: begin idx_q <= reg_wdata[15:0]; idx_en <= reg_wdata[31]; end
          default: ;
        endcase
      end
      if (data_rd) hw_rdy <= 1'b0;
      if (soft_clr) begin
        st <= IDLE; active <= 1'b0; nak <= 1'b0; hw_rdy <= 1'b0;
        scl_q <= 1'b0; sda_q <= 1'b0; ph <= '0; bc <= '0;
      end else begin
        case (st)
          IDLE, WAITP: if (cmd_go) begin
            ph <= '0;
            if (reg_wdata[27]) begin
              if (st == WAITP) st <= STOP;
            end else begin
              c_rd <= reg_wdata[1]; c_addr <= reg_wdata[8:2]; rem <= reg_wdata[17:9];
              c_ib <= reg_wdata[25:18]; c_idx <= reg_wdata[26];
              sp <= ADDR; pos <= '0; active <= 1'b1; st <= START;
            end
          end
          START: if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b1;
              default: begin scl_q <= 1'b1; bc <= '0; st <= BYTE; end
            endcase
          end
          STOP: if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b0;
              default: begin st <= IDLE; active <= 1'b0; end
            endcase
          end
          BYTE: if (tick && !stall) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_q <= (bc == 4'd8) ? (rx && rem != CNTW'(1)) : (!rx && !txbyte[3'd7 - bc[2:0]]);
              2'd1: scl_q <= 1'b0;
              2'd2: if (bc == 4'd8) ackbad <= sda_in; else rxsh <= {rxsh[6:0], sda_in};
              default: begin
                scl_q <= 1'b1;
                bc <= bc + 4'd1;
                if (bc == 4'd8) begin
                  bc <= '0;
                  if (!rx && ackbad) begin
                    nak <= 1'b1; st <= STOP;
                  end else if (sp == DATA) begin
                    rem <= rem - CNTW'(1);
                    pos <= pos + 2'd1;
                    if (rx) begin
                      if (pos == 2'd0) dbuf <= {24'b0, rxsh};
                      else dbuf[{pos, 3'b000} +: 8] <= rxsh;
                      if (pos == 2'd3 || rem == CNTW'(1)) hw_rdy <= 1'b1;
                    end else if (pos == 2'd3 && rem > CNTW'(1)) hw_rdy <= 1'b1;
                    if (rem == CNTW'(1)) st <= WAITP;
                  end else begin
                    sp <= nsp;
                    if (nsp == RADDR) st <= START;
                    else if (nsp == DATA && rem == '0) st <= WAITP;
                  end
                end
              end
            endcase
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {22'b0, sel_q};
      3'd2:    reg_rdata = dbuf;
      3'd3:    reg_rdata = {28'b0, active, in_wait, nak, hw_rdy};
      3'd4:    reg_rdata = {29'b0, ien_q};
      3'd5:    reg_rdata = {idx_en, 15'b0, idx_q};
      default: reg_rdata = '0;
    endcase
    if (ien_q[0])      irq = hw_rdy;
    else if (ien_q[1]) irq = in_wait;
    else if (ien_q[2]) irq = !active;
    else               irq = 1'b0;
  end

  assign pin_sel = sel_q[7:0];
  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;
  wire unused_ok = scl_in;
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic nak,
  input logic hw_rdy,
  input logic active,
  input logic in_wait,
  input logic in_byte,
  input logic soft_clr,
  input logic data_rd,
  input logic tick
);
  // R9
  nak_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak && !soft_clr |=> nak);
  // R8
  wait_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> scl_oe);
  // R11
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !scl_oe && !sda_oe);
  // R3
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_byte && $past(in_byte) && !scl_oe && !$past(scl_oe) |-> $stable(sda_oe));
  // R14
  rdy_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !tick |=> !hw_rdy);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_q), .sda_oe(sda_q), .nak(nak),
  .hw_rdy(hw_rdy), .active(active), .in_wait(in_wait), .in_byte(in_byte),
  .soft_clr(soft_clr), .data_rd(data_rd), .tick(tick)
);

// File: tb/i2c_cmd_master_tb.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb;
  localparam logic [6:0] SLV = 7'h50;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic [7:0] pin_sel;
  logic s_oe = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe | s_oe);
  int nchk = 0, nfail = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  i2c_cmd_master u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .pin_sel(pin_sel), .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe));

  // behavioural target: 0 idle, 1 address, 2 write, 3 read, 4 ignore
  int mode = 0, bitn = 0, rk = 0, nlog = 0;
  logic [7:0] sh = '0, rbyte = '0;
  logic mack = 1'b0;
  logic [7:0] log_q [0:63];

  function automatic logic [7:0] rdbyte(input int k);
    return 8'(k * 29 + 3);
  endfunction

  always @(negedge sda) if (scl) begin mode = 1; bitn = 0; s_oe = 1'b0; end
  always @(posedge sda) if (scl) begin mode = 0; s_oe = 1'b0; end
  always @(posedge scl) if (mode >= 1 && mode <= 3) begin
    if (bitn < 8) begin if (mode != 3) sh = {sh[6:0], sda}; end
    else mack = !sda;
    bitn++;
  end
  always @(negedge scl) if (mode >= 1 && mode <= 3) begin
    if (bitn == 8) begin
      if (mode == 1) begin
        log_q[nlog] = sh; nlog++;
        if (sh[7:1] == SLV) begin s_oe = 1'b1; mode = sh[0] ? 3 : 2; end
        else mode = 4;
      end else if (mode == 2) begin log_q[nlog] = sh; nlog++; s_oe = 1'b1; end
      else s_oe = 1'b0;
    end else if (bitn == 9) begin
      bitn = 0; s_oe = 1'b0;
      if (mode == 3) begin
        if (mack) begin rbyte = rdbyte(rk); rk++; s_oe = !rbyte[7]; end
        else mode = 4;
      end
    end else if (mode == 3) s_oe = !rbyte[3'(7 - bitn)];
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s act=%h exp=%h", what, act, exp); end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_bit(input int b, input bit v, input string what);
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rreg(3'd3, s);
      if (s[b] == v) return;
    end
    chk(1'b0, {what, " status wait timeout"}, s, 32'(v) << b);
  endtask

  function automatic logic [31:0] cmd(input bit rd, input logic [6:0] a, input int n,
                                      input logic [7:0] ib, input bit ixc, input bit stopc);
    return {4'b0, stopc, ixc, ib, 9'(n), a, rd, 1'b1};
  endfunction

  logic [7:0] wbuf [0:15];
  function automatic logic [31:0] wword(input int w);
    return {wbuf[4*w+3], wbuf[4*w+2], wbuf[4*w+1], wbuf[4*w]};
  endfunction

  task automatic stop_bus();
    wreg(3'd1, cmd(0, 7'h0, 0, 8'h0, 0, 1));
    wait_bit(3, 1'b0, "R11 stop");
  endtask

  // im: 0 none, 1 one-byte index, 2 two-byte index
  task automatic xfer(input bit rd, input int n, input int im, input logic [15:0] ix, input string tag);
    int base, hs, nw, k;
    logic [31:0] d, e;
    logic [7:0] ex [0:31];
    base = rk; hs = 0; nlog = 0; nw = (n + 3) / 4;
    if (im == 2) wreg(3'd5, {1'b1, 15'b0, ix});
    if (!rd) wreg(3'd2, wword(0));
    wreg(3'd1, cmd(rd, SLV, n, ix[7:0], im == 1, 0));
    for (int w = 0; w < nw; w++) begin
      if (rd) begin
        wait_bit(0, 1'b1, tag); hs++;
        rreg(3'd2, d);
        e = '0;
        for (int j = 0; j < 4; j++) if (4*w + j < n) e[8*j +: 8] = rdbyte(base + 4*w + j);
        chk(d == e, {tag, " R4 read word"}, d, e);
      end else if (w > 0) begin
        wait_bit(0, 1'b1, tag); hs++;
        wreg(3'd2, wword(w));
      end
    end
    wait_bit(2, 1'b1, {tag, " R8 wait phase"});
    chk(hs == (rd ? nw : (nw > 0 ? nw - 1 : 0)), {tag, " R3/R4 handshakes"}, 32'(hs), 32'(rd ? nw : nw - 1));
    k = 0;
    ex[k++] = {SLV, rd && im == 0};
    if (im == 2) begin ex[k++] = ix[15:8]; ex[k++] = ix[7:0]; end
    if (im == 1) ex[k++] = ix[7:0];
    if (rd && im != 0) ex[k++] = {SLV, 1'b1};
    if (!rd) for (int j = 0; j < n; j++) ex[k++] = wbuf[j];
    chk(nlog == k, {tag, " R5/R6/R7 byte count on bus"}, 32'(nlog), 32'(k));
    for (int j = 0; j < k && j < nlog; j++)
      chk(log_q[j] == ex[j], {tag, " R3/R5/R6/R7 bus byte"}, 32'(log_q[j]), 32'(ex[j]));
    if (im == 2) wreg(3'd5, 32'h0);
  endtask

  task automatic period(output int p);
    realtime t0, t1;
    @(posedge scl); t0 = $realtime;
    @(posedge scl); t1 = $realtime;
    p = int'((t1 - t0) / 10.0);
  endtask

  initial begin
    wait (cyc == 150000);
    nfail++; $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int p;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rreg(3'd3, s);
    chk(s == 0, "R1 status after reset", s, 0);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(irq == 1'b0, "R1 irq low", irq, 0);

    // R2 rate and pin select
    wreg(3'd0, {22'b0, 2'd0, 8'h5A});
    chk(pin_sel == 8'h5A, "R2 pin select", pin_sel, 8'h5A);
    wbuf[0] = 8'hC3;
    wreg(3'd2, wword(0));
    wreg(3'd1, cmd(0, SLV, 1, 8'h0, 0, 0));
    period(p);
    chk(p == 64, "R2 period rate 0", p, 64);
    wait_bit(2, 1'b1, "R2");
    stop_bus();
    wreg(3'd0, {22'b0, 2'd1, 8'h5A});
    wreg(3'd1, cmd(0, SLV, 1, 8'h0, 0, 0));
    period(p);
    chk(p == 32, "R2 period rate 1", p, 32);
    wait_bit(2, 1'b1, "R2");
    stop_bus();
    wreg(3'd0, {22'b0, 2'd3, 8'h01});
    rreg(3'd0, s);
    chk(s == 32'h301, "R2 select readback", s, 32'h301);

    // R3 write of 6 bytes, R5 indexed write
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h10 + i * 7);
    xfer(0, 6, 0, 16'h0, "R3 write6");
    chk(scl_oe == 1'b1, "R8 SCL held low in wait", scl_oe, 1);
    stop_bus();
    xfer(0, 9, 1, 16'h00A5, "R5 idx write9");
    stop_bus();
    // R6
    xfer(0, 3, 2, 16'hBEEF, "R6 idx16 write3");
    stop_bus();
    // R13
    xfer(0, 0, 1, 16'h0077, "R13 count0");
    stop_bus();
    // R4 / R7
    xfer(1, 5, 0, 16'h0, "R4 read5");
    stop_bus();
    xfer(1, 7, 1, 16'h0042, "R7 idx read7");
    stop_bus();

    // R12 / R14 interrupt selection
    wreg(3'd4, 32'h3);
    wreg(3'd1, cmd(1, SLV, 2, 8'h0, 0, 0));
    wait_bit(2, 1'b1, "R12");
    chk(irq == 1'b1, "R12 irq from hw-ready", irq, 1);
    rreg(3'd2, s);
    chk(s == {16'b0, rdbyte(rk - 1), rdbyte(rk - 2)}, "R4 partial word", s, {16'b0, rdbyte(rk - 1), rdbyte(rk - 2)});
    rreg(3'd3, s);
    chk(s[0] == 1'b0, "R14 ready cleared by read", s, s & ~32'h1);
    chk(irq == 1'b0, "R12 wait bit ignored when ready enabled", irq, 0);
    wreg(3'd4, 32'h6);
    #1 chk(irq == 1'b1, "R12 irq from wait phase", irq, 1);
    wreg(3'd4, 32'h4);
    #1 chk(irq == 1'b0, "R12 idle irq low while active", irq, 0);
    stop_bus();
    #1 chk(irq == 1'b1, "R12 idle irq", irq, 1);
    wreg(3'd4, 32'h0);

    // R8 stop cycle while idle ignored
    nlog = 0;
    wreg(3'd1, cmd(0, 7'h0, 0, 8'h0, 0, 1));
    repeat (40) @(negedge clk);
    rreg(3'd3, s);
    chk(s == 0 && !scl_oe && !sda_oe && nlog == 0, "R8 idle stop ignored", s, 0);

    // R9 / R10 missing acknowledge
    nlog = 0;
    wreg(3'd2, 32'h1234_5678);
    wreg(3'd1, cmd(0, 7'h33, 2, 8'h0, 0, 0));
    wait_bit(3, 1'b0, "R9");
    repeat (30) @(negedge clk);
    rreg(3'd3, s);
    chk(s == 32'h2, "R9 sticky error only", s, 32'h2);
    chk(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
    chk(nlog == 1, "R9 only address sent", nlog, 1);
    wreg(3'd1, 32'h8000_0000);
    wreg(3'd1, 32'h0);
    rreg(3'd3, s);
    chk(s == 0, "R10 soft clear", s, 0);

    // R10 soft clear mid transfer
    wreg(3'd2, 32'hFFFF_FFFF);
    wreg(3'd1, cmd(0, SLV, 8, 8'h0, 0, 0));
    repeat (100) @(negedge clk);
    wreg(3'd1, 32'h8000_0000);
    wreg(3'd1, 32'h0);
    mode = 0; s_oe = 1'b0;
    rreg(3'd3, s);
    chk(s == 0 && !scl_oe && !sda_oe, "R10 abort to idle", s, 0);

    // random chained transfers (repeated START between them)
    for (int it = 0; it < 10; it++) begin
      bit rd;
      int n, im;
      logic [15:0] ix;
      rd = 1'($urandom % 2);
      n = rd ? 1 + int'($urandom % 10) : int'($urandom % 11);
      im = int'($urandom % 3);
      ix = 16'($urandom);
      for (int j = 0; j < 16; j++) wbuf[j] = 8'($urandom);
      xfer(rd, n, im, ix, $sformatf("rand%0d R3/R4", it));
    end
    stop_bus();
    rreg(3'd3, s);
    chk(s == 0, "R11 idle at end", s, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule